// File: doc/BRIEF.md
# External Interrupt Request Latch

This block watches eight external interrupt pins, synchronises them and turns their activity into pending request flags that stay set until software clears them. Each pin is configured as rising-edge or high-level sensitive. The pins can also be regrouped, four at a time, into two encoded request groups: a nonzero four-bit value on a group's pins is a request at that level, and zero means idle.

Software reaches the block through a plain register port with a single-cycle write strobe and a single-cycle read strobe. Reads return data combinationally in the strobe cycle. Any side effect of a read takes place on the clock edge that ends that cycle. The port carries no streaming data, so it has no valid/ready handshake and no back-pressure. The outputs are the pending flag of each pin, and the pending flag and captured level of each group. A global no-retention bit makes level pins and groups report live activity instead of latched state.

How a request is cleared depends on how it was detected. An edge request needs a read that returns 1, followed by a write of 0. A level request or a group request is cleared by a write of 1 to the matching mask bit. Arbitration among requests and vector generation sit in the logic downstream of this block.

Top module: `ext_irq_latch`

## Requirements
- R1: Register map by address: 0 status, 1 pin mask set, 2 pin mask clear, 3 group mask, 4 level mask, 5 priority (pin i uses bits 4i+3..4i), 6 config (bit 0 no-retention, bits 15..8 edge select per pin with 1 meaning edge, bits 17..16 group enable). After reset the pending outputs, priorities and config read 0, the pin mask reads 0xFF, the group mask reads 0x3 and the level mask reads 0xFFFF.
- R2: A rising edge on an edge-selected pin sets that pin's pending flag, provided the pin is unmasked, has a nonzero priority and is not in an enabled group. The flag stays set after the pin falls.
- R3: An edge flag clears only when status bit i is written 0 after a status read returned 1 in that bit. A later status read that returns 0 in that bit withdraws the qualification. A write of 0 without qualification has no effect, and writing 1 never has an effect.
- R4: Writing 1 to a pin's bit in the mask set register does not clear a latched edge flag.
- R5: With no-retention at 0, a high level on a level-selected, unmasked, nonzero-priority pin latches its flag. The flag stays set after the pin drops, reads back as 1 in status, and is cleared by writing 1 to that pin's bit in the mask set register.
- R6: Writing 0 to a pin's priority field leaves an already latched level flag set. While the field is 0, the pin captures no new request.
- R7: With no-retention at 0, an enabled, unmasked group latches its nonzero input value and a pending flag. Both hold until a write to the group mask register puts 1 in bit 0 (for pins 3..0) or bit 1 (for pins 7..4). Group-enabled pins raise no pin flags.
- R8: Changing the level mask (bit k masks level k) never clears a latched group request. A masked level is not captured.
- R9: With no-retention at 1, level pin flags and group flags/levels follow the live synchronised inputs and return to 0 when the inputs go idle. Edge flags still latch.
- R10: When a new edge is detected in the same cycle as a qualified clearing write of 0, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 8 | Asynchronous external request pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (status reads qualify clears) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the read cycle |
| pin_pend_o | output | 8 | Pending flag per pin |
| grp_pend_o | output | 2 | Pending flag per group |
| grp_lvl_o | output | 8 | Captured or live level per group, 4 bits each |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle, and that the pins are quiet whenever a pin's mode or the group enables change. The bench meets this by going through one task per access and by reconfiguring only while every pin is low. Each stimulus holds a pin level for four cycles, longer than the three-register path from pin to latched flag, so every sample lands after the flag has settled. The test of an edge colliding with a clear is the only one timed to an exact cycle.

// File: rtl/eil_pkg.sv
package eil_pkg;
  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_MSET  = 3'd1,
    SEL_MCLR  = 3'd2,
    SEL_GMASK = 3'd3,
    SEL_LMASK = 3'd4,
    SEL_PRIO  = 3'd5,
    SEL_CFG   = 3'd6
  } reg_sel_e;

  localparam int CFG_RET_BIT  = 0;
  localparam int CFG_EDGE_LSB = 8;
  localparam int CFG_GRP_LSB  = 16;
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/eil_regs.sv
module eil_regs
  import eil_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int GRP_W    = 4,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32,
  localparam int NUM_GRPS = NUM_PINS / GRP_W,
  localparam int NUM_LVLS = 1 << GRP_W,
  localparam int PRIO_TW  = NUM_PINS * PRIO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [2:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_GRPS-1:0] gmask_o,
  output logic [NUM_LVLS-1:0] lmask_o,
  output logic [PRIO_TW-1:0]  prio_o,
  output logic                ret_off_o,
  output logic [NUM_PINS-1:0] edge_sel_o,
  output logic [NUM_GRPS-1:0] grp_en_o,
  output logic                stat_rd_o,
  output logic                stat_wr_o,
  output logic [NUM_PINS-1:0] mset_o,
  output logic [NUM_GRPS-1:0] gset_o
);
  reg_sel_e sel;
  logic     wr_mset, wr_mclr, wr_gmask, wr_lmask, wr_prio, wr_cfg;

  assign sel      = reg_sel_e'(addr_i);
  assign wr_mset  = wr_i && (sel == SEL_MSET);
  assign wr_mclr  = wr_i && (sel == SEL_MCLR);
  assign wr_gmask = wr_i && (sel == SEL_GMASK);
  assign wr_lmask = wr_i && (sel == SEL_LMASK);
  assign wr_prio  = wr_i && (sel == SEL_PRIO);
  assign wr_cfg   = wr_i && (sel == SEL_CFG);

  assign stat_rd_o = rd_i && (sel == SEL_STAT);
  assign stat_wr_o = wr_i && (sel == SEL_STAT);
  assign mset_o    = wr_mset  ? wdata_i[NUM_PINS-1:0] : '0;
  assign gset_o    = wr_gmask ? wdata_i[NUM_GRPS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o     <= '1;
      gmask_o    <= '1;
      lmask_o    <= '1;
      prio_o     <= '0;
      ret_off_o  <= 1'b0;
      edge_sel_o <= '0;
      grp_en_o   <= '0;
    end else begin
      if (wr_mset)       mask_o <= mask_o | wdata_i[NUM_PINS-1:0];
      else if (wr_mclr)  mask_o <= mask_o & ~wdata_i[NUM_PINS-1:0];
      if (wr_gmask) gmask_o <= wdata_i[NUM_GRPS-1:0];
      if (wr_lmask) lmask_o <= wdata_i[NUM_LVLS-1:0];
      if (wr_prio)  prio_o  <= wdata_i[PRIO_TW-1:0];
      if (wr_cfg) begin
        ret_off_o  <= wdata_i[CFG_RET_BIT];
        edge_sel_o <= wdata_i[CFG_EDGE_LSB +: NUM_PINS];
        grp_en_o   <= wdata_i[CFG_GRP_LSB +: NUM_GRPS];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_STAT:  rdata_o[NUM_PINS-1:0] = pend_i;
      SEL_MSET:  rdata_o[NUM_PINS-1:0] = mask_o;
      SEL_GMASK: rdata_o[NUM_GRPS-1:0] = gmask_o;
      SEL_LMASK: rdata_o[NUM_LVLS-1:0] = lmask_o;
      SEL_PRIO:  rdata_o[PRIO_TW-1:0]  = prio_o;
      SEL_CFG: begin
        rdata_o[CFG_RET_BIT]               = ret_off_o;
        rdata_o[CFG_EDGE_LSB +: NUM_PINS]  = edge_sel_o;
        rdata_o[CFG_GRP_LSB +: NUM_GRPS]   = grp_en_o;
      end
      default:   rdata_o = '0;
    endcase
  end

  // R1: a mask set write leaves every written bit masked on the next cycle
  p_mset_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_o & $past(wdata_i[NUM_PINS-1:0])) == $past(wdata_i[NUM_PINS-1:0])));
endmodule

// File: rtl/eil_pin_chan.sv
module eil_pin_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic edge_mode_i,
  input  logic masked_i,
  input  logic prio_nz_i,
  input  logic grp_sel_i,
  input  logic ret_off_i,
  input  logic stat_rd_i,
  input  logic stat_wr_i,
  input  logic stat_wbit_i,
  input  logic mset_i,
  output logic pend_o
);
  logic prev_q, held_q, qual_q;
  logic live, edge_det, level_det, clr_edge;

  assign live      = sync_i & ~masked_i & prio_nz_i & ~grp_sel_i;
  assign edge_det  = edge_mode_i & live & ~prev_q;
  assign level_det = ~edge_mode_i & live;
  assign clr_edge  = stat_wr_i & ~stat_wbit_i & qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (edge_mode_i) begin
        if (edge_det)      held_q <= 1'b1;
        else if (clr_edge) held_q <= 1'b0;
      end else begin
        if (ret_off_i)     held_q <= 1'b0;
        else if (mset_i)   held_q <= 1'b0;
        else if (level_det) held_q <= 1'b1;
      end
      if (stat_rd_i)                 qual_q <= pend_o & edge_mode_i;
      else if (clr_edge && !edge_det) qual_q <= 1'b0;
    end
  end

  assign pend_o = (!edge_mode_i && ret_off_i) ? level_det : held_q;

  // R2: a detected edge always leaves the flag set
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> held_q);
  // R3: an unqualified write of 0 leaves an edge flag alone
  p_unqual_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && held_q && stat_wr_i && !qual_q) |=> held_q);
  // R3: a qualified write of 0 with no new edge drops the flag
  p_qual_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && stat_wr_i && !stat_wbit_i && qual_q && !edge_det) |=> !held_q);
  // R4: mask set write does not touch an edge flag
  p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && held_q && mset_i && !stat_wr_i) |=> held_q);
  // R5: mask set write clears a retained level flag
  p_lvl_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode_i && !ret_off_i && mset_i) |=> !held_q);
  // R6: without a mask write a retained level flag persists
  p_lvl_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode_i && !ret_off_i && held_q && !mset_i) |=> held_q);
  // R9: nothing is retained for a level pin in no-retention mode
  p_no_retain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode_i && ret_off_i) |=> !held_q);
  // R10: a clear colliding with a new edge keeps the flag
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && clr_edge) |=> held_q);
endmodule

// File: rtl/eil_grp_chan.sv
module eil_grp_chan #(
  parameter int GRP_W = 4,
  localparam int NUM_LVLS = 1 << GRP_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [GRP_W-1:0]    sync_i,
  input  logic                grp_en_i,
  input  logic                gmask_i,
  input  logic [NUM_LVLS-1:0] lmask_i,
  input  logic                ret_off_i,
  input  logic                gset_i,
  output logic                pend_o,
  output logic [GRP_W-1:0]    lvl_o
);
  logic             held_q;
  logic [GRP_W-1:0] lvl_q;
  logic             live_det;

  assign live_det = grp_en_i & ~gmask_i & (sync_i != '0) & ~lmask_i[sync_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      lvl_q  <= '0;
    end else if (ret_off_i || gset_i) begin
      held_q <= 1'b0;
      lvl_q  <= '0;
    end else if (live_det && !held_q) begin
      held_q <= 1'b1;
      lvl_q  <= sync_i;
    end
  end

  assign pend_o = ret_off_i ? live_det : held_q;
  assign lvl_o  = ret_off_i ? (live_det ? sync_i : '0) : lvl_q;

  // R7: writing 1 to the group mask bit clears the group request
  p_grp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_off_i && gset_i) |=> !held_q);
  // R8: level mask changes never drop a retained group request
  p_lmask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !ret_off_i && !gset_i) |=> held_q);
  // R7: the captured level is frozen while retained
  p_lvl_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !ret_off_i && !gset_i) |=> $stable(lvl_q));
  // R7: a retained level is never zero
  p_lvl_nz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> (lvl_q != '0));
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import eil_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int GRP_W    = 4,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32,
  localparam int NUM_GRPS = NUM_PINS / GRP_W,
  localparam int NUM_LVLS = 1 << GRP_W,
  localparam int PRIO_TW  = NUM_PINS * PRIO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PINS-1:0]       irq_pin_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [2:0]                reg_addr_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  output logic [DATA_W-1:0]         reg_rdata_o,
  output logic [NUM_PINS-1:0]       pin_pend_o,
  output logic [NUM_GRPS-1:0]       grp_pend_o,
  output logic [NUM_GRPS*GRP_W-1:0] grp_lvl_o
);
  logic [NUM_PINS-1:0] pin_sync, mask, edge_sel, mset;
  logic [NUM_GRPS-1:0] gmask, grp_en, gset;
  logic [NUM_LVLS-1:0] lmask;
  logic [PRIO_TW-1:0]  prio;
  logic                ret_off, stat_rd, stat_wr;

  eil_sync #(.W(NUM_PINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(irq_pin_i), .sync_o(pin_sync)
  );

  eil_regs #(
    .NUM_PINS(NUM_PINS), .GRP_W(GRP_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .pend_i(pin_pend_o),
    .mask_o(mask), .gmask_o(gmask), .lmask_o(lmask), .prio_o(prio),
    .ret_off_o(ret_off), .edge_sel_o(edge_sel), .grp_en_o(grp_en),
    .stat_rd_o(stat_rd), .stat_wr_o(stat_wr), .mset_o(mset), .gset_o(gset)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    eil_pin_chan pin_i (
      .clk(clk), .rst_n(rst_n),
      .sync_i(pin_sync[p]),
      .edge_mode_i(edge_sel[p]),
      .masked_i(mask[p]),
      .prio_nz_i(|prio[p*PRIO_W +: PRIO_W]),
      .grp_sel_i(grp_en[p / GRP_W]),
      .ret_off_i(ret_off),
      .stat_rd_i(stat_rd),
      .stat_wr_i(stat_wr),
      .stat_wbit_i(reg_wdata_i[p]),
      .mset_i(mset[p]),
      .pend_o(pin_pend_o[p])
    );
  end

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    eil_grp_chan #(.GRP_W(GRP_W)) grp_i (
      .clk(clk), .rst_n(rst_n),
      .sync_i(pin_sync[g*GRP_W +: GRP_W]),
      .grp_en_i(grp_en[g]),
      .gmask_i(gmask[g]),
      .lmask_i(lmask),
      .ret_off_i(ret_off),
      .gset_i(gset[g]),
      .pend_o(grp_pend_o[g]),
      .lvl_o(grp_lvl_o[g*GRP_W +: GRP_W])
    );
  end

  // R1: a single access strobe per cycle is assumed of the register port
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_rd_i));
endmodule

// File: tb/ext_irq_latch_tb_top.sv
module ext_irq_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin_pend;
  logic [1:0]  grp_pend;
  logic [7:0]  grp_lvl;
  int          checks = 0, failures = 0, cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pins),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_pend_o(pin_pend), .grp_pend_o(grp_pend), .grp_lvl_o(grp_lvl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); pins = v; idle(4);
    pins = '0; idle(4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 pin_pend", {24'd0, pin_pend}, 32'd0);
    chk("R1 grp_pend", {30'd0, grp_pend}, 32'd0);
    rd_reg(3'd1, d); chk("R1 pin mask", d, 32'hFF);
    rd_reg(3'd3, d); chk("R1 group mask", d, 32'h3);
    rd_reg(3'd4, d); chk("R1 level mask", d, 32'hFFFF);
    rd_reg(3'd5, d); chk("R1 priority", d, 32'h0);
    rd_reg(3'd6, d); chk("R1 config", d, 32'h0);

    // Edge sweep over every pin
    wr_reg(3'd5, 32'h1111_1111);
    wr_reg(3'd6, 32'h0000_FF00);
    wr_reg(3'd2, 32'hFF);
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      chk("R2 edge latched", {24'd0, pin_pend}, 32'(1 << i));
      wr_reg(3'd0, 32'h0);
      chk("R3 unqualified write 0", {24'd0, pin_pend}, 32'(1 << i));
      wr_reg(3'd1, 32'(1 << i));
      chk("R4 mask keeps edge", {24'd0, pin_pend}, 32'(1 << i));
      wr_reg(3'd2, 32'hFF);
      rd_reg(3'd0, d);
      chk("R3 status read", d, 32'(1 << i));
      wr_reg(3'd0, 32'(8'hFF & ~(8'(1 << i))));
      chk("R3 qualified clear", {24'd0, pin_pend}, 32'd0);
    end

    // R3 qualification withdrawn by a read returning 0
    pulse(8'h10);
    rd_reg(3'd0, d);
    wr_reg(3'd0, 32'h0);
    chk("R3 cleared pin4", {24'd0, pin_pend}, 32'd0);
    rd_reg(3'd0, d);
    pulse(8'h10);
    wr_reg(3'd0, 32'h0);
    chk("R3 withdrawn qualification", {24'd0, pin_pend}, 32'h10);
    rd_reg(3'd0, d); wr_reg(3'd0, 32'h0);

    // R10 edge colliding with a qualified clear
    pulse(8'h01);
    rd_reg(3'd0, d);
    @(negedge clk); pins = 8'h01;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = 3'd0; wdata = 32'h0;
    @(negedge clk); wr = 1'b0;
    idle(3); pins = '0; idle(3);
    chk("R10 edge wins over clear", {24'd0, pin_pend}, 32'h01);
    rd_reg(3'd0, d); wr_reg(3'd0, 32'h0);
    chk("R10 cleanup", {24'd0, pin_pend}, 32'd0);

    // Level sweep with retention
    wr_reg(3'd6, 32'h0);
    for (int i = 0; i < 8; i++) begin
      pulse(8'(1 << i));
      chk("R5 level retained", {24'd0, pin_pend}, 32'(1 << i));
      rd_reg(3'd0, d);
      chk("R5 level readback", d, 32'(1 << i));
      wr_reg(3'd5, 32'h1111_1111 & ~(32'hF << (4 * i)));
      chk("R6 priority 0 keeps", {24'd0, pin_pend}, 32'(1 << i));
      wr_reg(3'd5, 32'h1111_1111);
      wr_reg(3'd1, 32'(1 << i));
      chk("R5 mask set clears level", {24'd0, pin_pend}, 32'd0);
      wr_reg(3'd2, 32'hFF);
    end
    wr_reg(3'd5, 32'h1111_1011);
    pulse(8'h04);
    chk("R6 priority 0 blocks capture", {24'd0, pin_pend}, 32'd0);
    wr_reg(3'd5, 32'h1111_1111);

    // Group sweep
    wr_reg(3'd6, 32'h0003_0000);
    wr_reg(3'd3, 32'h0);
    wr_reg(3'd4, 32'h0);
    for (int g = 0; g < 2; g++) begin
      for (int v = 1; v < 16; v++) begin
        pulse(8'(v << (4 * g)));
        chk("R7 group pending", {30'd0, grp_pend}, 32'(1 << g));
        chk("R7 group level", {24'd0, grp_lvl}, 32'(v << (4 * g)));
        chk("R7 no pin flag", {24'd0, pin_pend}, 32'd0);
        wr_reg(3'd4, 32'hFFFF);
        chk("R8 level mask keeps", {30'd0, grp_pend}, 32'(1 << g));
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd3, 32'(1 << g));
        chk("R7 group mask clears", {30'd0, grp_pend}, 32'd0);
        wr_reg(3'd3, 32'h0);
      end
    end
    wr_reg(3'd4, 32'h0020);
    pulse(8'h05);
    chk("R8 masked level ignored", {30'd0, grp_pend}, 32'd0);
    wr_reg(3'd4, 32'h0);

    // No-retention mode
    wr_reg(3'd6, 32'h0000_0001);
    @(negedge clk); pins = 8'h08; idle(4);
    chk("R9 level follows high", {24'd0, pin_pend}, 32'h08);
    pins = '0; idle(4);
    chk("R9 level follows low", {24'd0, pin_pend}, 32'd0);
    wr_reg(3'd6, 32'h0002_0001);
    @(negedge clk); pins = 8'h90; idle(4);
    chk("R9 group follows high", {30'd0, grp_pend}, 32'h2);
    chk("R9 group live level", {24'd0, grp_lvl}, 32'h90);
    pins = '0; idle(4);
    chk("R9 group follows low", {30'd0, grp_pend}, 32'd0);
    wr_reg(3'd6, 32'h0000_FF01);
    pulse(8'h04);
    chk("R9 edge still latched", {24'd0, pin_pend}, 32'h04);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule